// File: doc/BRIEF.md
# Indexed Register Move Unit

This unit performs a vector gather across the register file. Each destination element gets a copy of the register found at a base register plus an index. The indices sit packed in a run of index registers, and their size is chosen per operation. With small indices, several of them share one register. For example, four 8-bit indices cover a vector of length four using a single index register.

The unit steps through VL outer iterations of SUBVL inner elements and issues one move per clock. Each move needs one index-register read, one source-register read and one write. In normal mode the index position advances with every element. In subvector mode the index position restarts for each subvector and the offsets stay local to that subvector, which makes transposition-style shuffles possible.

A seven-bit function code selects the index width and whether the integer or the floating-point register file is meant. The unit reports that choice on `fp_o`, and the surrounding datapath steers the ports to the right file.

Top module: `idx_move_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `wr_en_o` and `err_o` are all 0.
- R2: Element e = i*SUBVL + j (outer i, inner j) is written to register rd+e with the value read from its source register.
- R3: In normal mode (`subvl_mode_i`=0) element e uses packed index k=e, and its source register is base + index[k].
- R4: In subvector mode (`subvl_mode_i`=1) element e uses packed index k=j, and its source register is base + i*SUBVL + index[j].
- R5: Index width code: 0 = XLEN bits, 1 = 8, 2 = 16, 3 = 32. Index k has byte width B and lies in register idx_reg + (k*B)/(XLEN/8), at byte lane (k*B) mod (XLEN/8). Lane 0 is bits 7:0. The index is zero-extended.
- R6: One element is issued per clock. `done_o` pulses for one cycle in the cycle after the last element. When VL*SUBVL is 0, `done_o` pulses in the cycle after start and nothing is written.
- R7: If a source register number is above NREG-1, that element is not written and `err_o` is set. `err_o` holds until the next accepted start, and the remaining elements still proceed.
- R8: `funct7_i` is valid when bits 6:5, bit 2 and bit 0 are all 0. Bits 4:3 give the width code and bit 1 drives `fp_o` (1 = floating point). An invalid code writes nothing and pulses `done_o` with `err_o` set.
- R9: `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| funct7_i | input | 7 | Function code: index width and file select |
| base_reg_i | input | AW | Base register of the source block |
| idx_reg_i | input | AW | First register of the packed indices |
| rd_i | input | AW | First destination register |
| vl_i | input | VL_W | Outer vector length |
| subvl_i | input | SUB_W | Subvector length |
| subvl_mode_i | input | 1 | 1 = offsets local to each subvector |
| idx_raddr_o | output | AW | Index-register read address |
| idx_rdata_i | input | XLEN | Index-register read data (same cycle) |
| src_raddr_o | output | AW | Source-register read address |
| src_rdata_i | input | XLEN | Source-register read data (same cycle) |
| wr_en_o | output | 1 | Destination write enable |
| wr_addr_o | output | AW | Destination register |
| wr_data_o | output | XLEN | Destination data |
| fp_o | output | 1 | Register file select for the operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Range or decode error of the last operation |

## Verification
The bench sweeps every width code, both iteration modes, and VL and SUBVL from 1 to 4, with random packed indices. Occasionally it plants an index large enough to overflow the register file.

Each kind of fault shows up as a specific symptom:
- Wrong lane arithmetic fetches a neighbouring index, so a wrong register value appears at the destination.
- A swapped mode applies the subvector offset twice or not at all.
- A missing range check writes data gathered from a wrapped address.
- An off-by-one count makes `done_o` arrive a cycle early or late.

Separate cases cover an empty vector, an invalid function code, a start pulse during an operation and a base near the top of the file.

// File: rtl/imv_pkg.sv
package imv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } imv_state_e;

  localparam logic [1:0] IW_XLEN = 2'd0;
  localparam logic [1:0] IW_8    = 2'd1;
  localparam logic [1:0] IW_16   = 2'd2;
  localparam logic [1:0] IW_32   = 2'd3;
endpackage

// File: rtl/imv_decode.sv
module imv_decode (
  input  logic [6:0] funct7_i,
  output logic       valid_o,
  output logic       fp_o,
  output logic [1:0] iw_o
);
  assign valid_o = (funct7_i[6:5] == 2'b00) && !funct7_i[2] && !funct7_i[0];
  assign fp_o    = funct7_i[1];
  assign iw_o    = funct7_i[4:3];
endmodule

// File: rtl/imv_seq.sv
module imv_seq
  import imv_pkg::*;
#(
  parameter int VL_W  = 5,
  parameter int SUB_W = 3,
  parameter int E_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmd_ok_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W-1:0] subvl_i,
  output logic             accept_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [VL_W-1:0]  outer_o,
  output logic [SUB_W-1:0] inner_o,
  output logic [E_W-1:0]   elem_o,
  output logic [SUB_W-1:0] subvl_o
);
  imv_state_e       state_q;
  logic [VL_W-1:0]  vl_q, outer_q;
  logic [SUB_W-1:0] subvl_q, inner_q;
  logic [E_W-1:0]   elem_q;
  logic             inner_last, last;

  assign accept_o   = start_i && (state_q == ST_IDLE);
  assign inner_last = (inner_q == subvl_q - SUB_W'(1));
  assign last       = inner_last && (outer_q == vl_q - VL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      subvl_q <= '0;
      outer_q <= '0;
      inner_q <= '0;
      elem_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          vl_q    <= vl_i;
          subvl_q <= subvl_i;
          outer_q <= '0;
          inner_q <= '0;
          elem_q  <= '0;
          if (!cmd_ok_i || vl_i == '0 || subvl_i == '0) state_q <= ST_DONE;
          else                                         state_q <= ST_RUN;
        end
        ST_RUN: begin
          elem_q <= elem_q + E_W'(1);
          if (inner_last) begin
            inner_q <= '0;
            outer_q <= outer_q + VL_W'(1);
          end else begin
            inner_q <= inner_q + SUB_W'(1);
          end
          if (last) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign outer_o = outer_q;
  assign inner_o = inner_q;
  assign elem_o  = elem_q;
  assign subvl_o = subvl_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> busy_o);
endmodule

// File: rtl/imv_index.sv
module imv_index
  import imv_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int KW   = 7
) (
  input  logic [1:0]      iw_i,
  input  logic [AW-1:0]   idx_base_i,
  input  logic [KW-1:0]   k_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [AW-1:0]   raddr_o,
  output logic [XLEN-1:0] val_o
);
  localparam int XB  = XLEN / 8;
  localparam int XSH = $clog2(XB);
  localparam int BW  = KW + XSH;

  logic [BW-1:0]   boff, word;
  logic [XSH-1:0]  lane;
  logic [XLEN-1:0] shifted;

  always_comb begin
    unique case (iw_i)
      IW_8:    boff = BW'(k_i);
      IW_16:   boff = BW'(k_i) << 1;
      IW_32:   boff = BW'(k_i) << 2;
      default: boff = BW'(k_i) << XSH;
    endcase
  end

  assign word    = boff >> XSH;
  assign lane    = boff[XSH-1:0];
  assign raddr_o = idx_base_i + AW'(word);
  assign shifted = rdata_i >> {lane, 3'b000};

  always_comb begin
    unique case (iw_i)
      IW_8:    val_o = XLEN'(shifted[7:0]);
      IW_16:   val_o = XLEN'(shifted[15:0]);
      IW_32:   val_o = XLEN'(shifted[31:0]);
      default: val_o = shifted;
    endcase
  end
endmodule

// File: rtl/idx_move_unit.sv
module idx_move_unit
  import imv_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NREG      = 32,
  parameter int MAX_VL    = 16,
  parameter int MAX_SUBVL = 4,
  parameter int AW        = $clog2(NREG),
  parameter int VL_W      = $clog2(MAX_VL + 1),
  parameter int SUB_W     = $clog2(MAX_SUBVL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [6:0]       funct7_i,
  input  logic [AW-1:0]    base_reg_i,
  input  logic [AW-1:0]    idx_reg_i,
  input  logic [AW-1:0]    rd_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [SUB_W-1:0] subvl_i,
  input  logic             subvl_mode_i,
  output logic [AW-1:0]    idx_raddr_o,
  input  logic [XLEN-1:0]  idx_rdata_i,
  output logic [AW-1:0]    src_raddr_o,
  input  logic [XLEN-1:0]  src_rdata_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [XLEN-1:0]  wr_data_o,
  output logic             fp_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int E_W = $clog2(MAX_VL * MAX_SUBVL + 1);
  localparam int SW  = XLEN + E_W + 2;

  logic             cmd_ok, dec_fp, accept, run;
  logic [1:0]       dec_iw;
  logic [VL_W-1:0]  outer;
  logic [SUB_W-1:0] inner, subvl_q;
  logic [E_W-1:0]   elem, k;
  logic [XLEN-1:0]  idx_val;
  logic [AW-1:0]    base_q, idx_q, rd_q;
  logic [1:0]       iw_q;
  logic             mode_q, fp_q, err_q;
  logic [SW-1:0]    sub_off, src_full;
  logic             src_ok;

  imv_decode u_dec (
    .funct7_i (funct7_i),
    .valid_o  (cmd_ok),
    .fp_o     (dec_fp),
    .iw_o     (dec_iw)
  );

  imv_seq #(.VL_W(VL_W), .SUB_W(SUB_W), .E_W(E_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cmd_ok_i (cmd_ok),
    .vl_i     (vl_i),
    .subvl_i  (subvl_i),
    .accept_o (accept),
    .run_o    (run),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .outer_o  (outer),
    .inner_o  (inner),
    .elem_o   (elem),
    .subvl_o  (subvl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
      rd_q   <= '0;
      iw_q   <= IW_XLEN;
      mode_q <= 1'b0;
      fp_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      base_q <= base_reg_i;
      idx_q  <= idx_reg_i;
      rd_q   <= rd_i;
      iw_q   <= dec_iw;
      mode_q <= subvl_mode_i;
      fp_q   <= dec_fp;
      err_q  <= !cmd_ok;
    end else if (run && !src_ok) begin
      err_q  <= 1'b1;
    end
  end

  // subvector mode restarts the index position per subvector
  assign k = mode_q ? E_W'(inner) : elem;

  imv_index #(.XLEN(XLEN), .AW(AW), .KW(E_W)) u_idx (
    .iw_i       (iw_q),
    .idx_base_i (idx_q),
    .k_i        (k),
    .rdata_i    (idx_rdata_i),
    .raddr_o    (idx_raddr_o),
    .val_o      (idx_val)
  );

  assign sub_off  = mode_q ? SW'(outer) * SW'(subvl_q) : '0;
  assign src_full = SW'(base_q) + SW'(idx_val) + sub_off;
  assign src_ok   = (src_full <= SW'(NREG - 1));

  assign src_raddr_o = src_full[AW-1:0];
  assign wr_en_o     = run && src_ok;
  assign wr_addr_o   = rd_q + AW'(elem);
  assign wr_data_o   = src_rdata_i;
  assign fp_o        = fp_q;
  assign err_o       = err_q;

  p_dest_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> (wr_addr_o == $past(wr_addr_o) + AW'(1)));

  p_src_above_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (src_raddr_o >= base_q));

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !accept) |=> err_o);

  p_fp_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(fp_o));

  p_no_write_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || done_o) |-> !wr_en_o);
endmodule

// File: tb/test_idx_move_unit.sv
module test_idx_move_unit;
  localparam int XLEN = 32, NREG = 64, AW = 6, VL_W = 5, SUB_W = 3;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic             start = 0, mode = 0;
  logic [6:0]       funct7 = '0;
  logic [AW-1:0]    base = '0, idxr = '0, rd = '0;
  logic [VL_W-1:0]  vl = '0;
  logic [SUB_W-1:0] subvl = '0;
  logic [AW-1:0]    idx_raddr, src_raddr, wr_addr;
  logic [XLEN-1:0]  idx_rdata, src_rdata, wr_data;
  logic             wr_en, fp, busy, done, err;

  logic [31:0] rf [NREG];
  logic [31:0] exp_rf [NREG];
  int errors = 0, checks = 0;
  bit finished = 0;

  assign idx_rdata = rf[idx_raddr];
  assign src_rdata = rf[src_raddr];
  always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

  idx_move_unit #(.XLEN(XLEN), .NREG(NREG)) i_idx_move_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .funct7_i(funct7),
    .base_reg_i(base), .idx_reg_i(idxr), .rd_i(rd), .vl_i(vl), .subvl_i(subvl),
    .subvl_mode_i(mode), .idx_raddr_o(idx_raddr), .idx_rdata_i(idx_rdata),
    .src_raddr_o(src_raddr), .src_rdata_i(src_rdata), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .fp_o(fp), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int bytes_of(input int code);
    return (code == 1) ? 1 : (code == 2) ? 2 : 4;
  endfunction

  // R5 layout: reg idxr + (k*B)/4, lane (k*B)%4
  task automatic put_idx(input int code, input int ir, input int k, input int unsigned v);
    int b = bytes_of(code);
    int bo = k * b;
    int r = ir + bo / 4;
    int ln = bo % 4;
    for (int q = 0; q < b; q++) rf[r][(ln + q) * 8 +: 8] = 8'((v >> (8 * q)) & 255);
  endtask

  function automatic int unsigned get_idx(input int code, input int ir, input int k);
    int b = bytes_of(code);
    int bo = k * b;
    int unsigned w = rf[ir + bo / 4] >> ((bo % 4) * 8);
    if (b == 4) return w;
    return w & ((32'd1 << (b * 8)) - 1);
  endfunction

  task automatic prefill();
    for (int r = 0; r < NREG; r++) rf[r] = 32'hC0DE_0000 + r;
    for (int r = 16; r < 32; r++) rf[r] = '0;
  endtask

  // one operation, full expected-state comparison
  task automatic run_op(input logic [6:0] f7, input int b, input int ir, input int d,
                        input int v, input int s, input bit m, input bit poke);
    bit valid = (f7[6:5] == 0) && !f7[2] && !f7[0];
    int code = f7[4:3];
    bit exp_err = !valid;
    int n = valid ? v * s : 0;
    int cyc = 0;
    for (int r = 0; r < NREG; r++) exp_rf[r] = rf[r];
    if (valid)
      for (int i = 0; i < v; i++)
        for (int j = 0; j < s; j++) begin
          int e = i * s + j;
          longint src = m ? longint'(b) + i * s + get_idx(code, ir, j)   // R4
                          : longint'(b) + get_idx(code, ir, e);          // R3
          if (src > NREG - 1) exp_err = 1;                               // R7
          else exp_rf[d + e] = rf[src];                                  // R2
        end
    @(negedge clk);
    funct7 = f7; base = AW'(b); idxr = AW'(ir); rd = AW'(d);
    vl = VL_W'(v); subvl = SUB_W'(s); mode = m; start = 1;
    @(negedge clk);
    start = 0;
    if (n > 0) chk(fp == f7[1], "R8 fp select", fp, f7[1]);
    while (!done && cyc < 200) begin
      if (poke && cyc == 1) begin start = 1; rd = AW'(48); end
      @(negedge clk);
      start = 0;
      cyc++;
    end
    chk(cyc == n, "R6 done timing", cyc, n);
    chk(err == exp_err, "R7/R8 err flag", err, exp_err);
    for (int r = 32; r < NREG; r++)
      chk(rf[r] == exp_rf[r], "R2 dest contents", rf[r], exp_rf[r]);
    @(negedge clk);
    chk(!busy && !done, "R6 returns idle", {busy, done}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    prefill();
    #23;
    chk(!busy && !done && !wr_en && !err, "R1 reset state", {busy, done, wr_en, err}, 0);
    rst_n = 1;
    // sweep: width code, mode, VL, SUBVL (R3 R4 R5 R6)
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 2; m++)
        for (int v = 1; v <= 4; v++)
          for (int s = 1; s <= 4; s++) begin
            prefill();
            for (int k = 0; k < v * s; k++)
              put_idx(c, 16, k, ($urandom % 10 == 0) ? 32'hF0 : $urandom % 8);
            run_op({2'b00, 2'(c), 1'b0, 1'(m ^ c[0]), 1'b0}, 0, 16, 32, v, s, bit'(m), 0);
          end
    // R7: base near top of file, some sources overflow
    prefill();
    for (int k = 0; k < 8; k++) put_idx(1, 16, k, k);
    run_op(7'b0001000, 58, 16, 32, 8, 1, 0, 0);
    // R6: empty vector
    prefill();
    run_op(7'b0001000, 0, 16, 32, 0, 3, 0, 0);
    run_op(7'b0001000, 0, 16, 32, 3, 0, 1, 0);
    // R8: invalid function codes
    prefill();
    run_op(7'b0000001, 0, 16, 32, 4, 1, 0, 0);
    run_op(7'b0100000, 0, 16, 32, 4, 1, 0, 0);
    // R9: start during an operation is ignored
    prefill();
    for (int k = 0; k < 12; k++) put_idx(2, 16, k, $urandom % 8);
    run_op(7'b0010010, 0, 16, 32, 4, 3, 0, 1);
    // err clears on the next accepted start (R7)
    prefill();
    put_idx(1, 16, 0, 2);
    run_op(7'b0001000, 0, 16, 32, 1, 1, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule